// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point operands in the standard interchange layout. The layout is a sign bit, then a biased exponent field, then a fraction field with a hidden leading one. With the default parameters the format is 32-bit single precision with an 8-bit exponent and a 23-bit fraction. The operation is a two-stage pipeline. Stage one classifies both operands, sums the biased exponents and removes the bias, multiplies the full significands and normalises the double-width product by at most one place. It also extracts the round and sticky bits from the bits that are dropped. Stage two rounds in one of four modes, detects exponent overflow and underflow, substitutes the special values, and packs the result.

A caller presents `a_i`, `b_i` and `rmode_i` together with a `valid_i` strobe, and accepts a new operation every cycle. Results below the normal range are flushed to a signed zero. Operands whose exponent field is zero are treated as zero.

Top module: `fpm_mul`

## Requirements
- R1: Every result that is not a NaN carries a sign equal to the XOR of the two operand sign bits. This includes zeros, infinities, saturated results and flushed results.
- R2: For two normal operands the biased result exponent is EA + EB − bias, plus one when the significand product is 2 or more. When no dropped product bit is set, the fraction is the exact product bits below the leading one.
- R3: With `rmode_i` = 0 the result is rounded to nearest. An exact tie is resolved toward an even fraction.
- R4: With `rmode_i` = 1 the result is truncated toward zero.
- R5: With `rmode_i` = 2 the magnitude of a positive result is incremented when any dropped bit is set. With `rmode_i` = 3 the same is done for a negative result. The opposite sign is truncated in both modes.
- R6: When rounding carries out of an all-ones fraction, the fraction becomes zero and the exponent rises by one.
- R7: If the rounded biased exponent reaches all ones, `ovf_o` is raised. The result is infinity in mode 0 and in the directed mode that points away from zero for that sign. In every other case it is the largest finite value (exponent all ones minus one, fraction all ones).
- R8: If the rounded biased exponent is zero or negative, `unf_o` is raised and the result is a zero with the sign from R1.
- R9: A NaN operand (exponent all ones, fraction nonzero) yields the canonical NaN, with both flags low. The canonical NaN has sign 0, exponent all ones and only the top fraction bit set.
- R10: Zero times infinity, in either order, yields the canonical NaN of R9 with both flags low.
- R11: Infinity times any non-NaN, nonzero operand yields infinity with both flags low.
- R12: An operand whose exponent field is zero, multiplied by a finite operand, yields zero with both flags low.
- R13: `valid_o` rises exactly two cycles after `valid_i`. While `rst_ni` is low, `valid_o`, `result_o` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| a_i | input | 1+EXP_W+FRAC_W | First operand |
| b_i | input | 1+EXP_W+FRAC_W | Second operand |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward −inf |
| valid_o | output | 1 | Result is valid |
| result_o | output | 1+EXP_W+FRAC_W | Packed product |
| ovf_o | output | 1 | Exponent overflow on this result |
| unf_o | output | 1 | Exponent underflow, result flushed |

## Verification
The properties assume that `valid_i`, the operands and the mode are stable and known at each rising edge. They also assume that `valid_i` is held low while reset is asserted, because the latency and operand-based checks look two cycles back only after two post-reset edges have passed. The bench drives every input on the falling edge and keeps `valid_i` low throughout reset, so every sampled value is settled. The sweep uses an 8-bit format with a 4-bit exponent and a 3-bit fraction. It walks every operand pair in nearest-even mode and a strided quarter of the pairs in the other three modes, with idle cycles between rows to exercise the strobe latency.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    RM_RNE = 2'd0,
    RM_RTZ = 2'd1,
    RM_RUP = 2'd2,
    RM_RDN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    K_FIN  = 2'd0,
    K_ZERO = 2'd1,
    K_INF  = 2'd2,
    K_NAN  = 2'd3
  } kind_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       sig_o,
  output kind_e                 kind_o
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max, exp_min;

  assign sign_o  = op_i[EXP_W+FRAC_W];
  assign exp_o   = op_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac    = op_i[FRAC_W-1:0];
  assign exp_max = &exp_o;
  assign exp_min = ~|exp_o;
  assign sig_o   = {1'b1, frac};

  // denormal inputs are treated as zero
  always_comb begin
    if (exp_max)      kind_o = (|frac) ? K_NAN : K_INF;
    else if (exp_min) kind_o = K_ZERO;
    else              kind_o = K_FIN;
  end
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int XE_W   = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [SIG_W-1:0]  sig_a_i,
  input  logic [SIG_W-1:0]  sig_b_i,
  output logic [XE_W-1:0]   exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              rnd_o,
  output logic              stk_o
);
  logic [PROD_W-1:0] prod;
  logic [XE_W-1:0]   esum;
  logic              hi;

  assign prod = PROD_W'(sig_a_i) * PROD_W'(sig_b_i);
  // two's complement: wraps to a negative value when the sum is below the bias
  assign esum = XE_W'(exp_a_i) + XE_W'(exp_b_i) - XE_W'(BIAS);
  assign hi   = prod[PROD_W-1];

  always_comb begin
    if (hi) begin
      exp_o  = esum + XE_W'(1);
      frac_o = prod[PROD_W-2 -: FRAC_W];
      rnd_o  = prod[FRAC_W];
      stk_o  = |prod[FRAC_W-1:0];
    end else begin
      exp_o  = esum;
      frac_o = prod[PROD_W-3 -: FRAC_W];
      rnd_o  = prod[FRAC_W-1];
      stk_o  = |prod[FRAC_W-2:0];
    end
  end
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W    = 1 + EXP_W + FRAC_W,
  localparam int XE_W = EXP_W + 2,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  kind_e             kind_i,
  input  logic              sign_i,
  input  logic [XE_W-1:0]   exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              rnd_i,
  input  logic              stk_i,
  input  rmode_e            rmode_i,
  output logic [W-1:0]      res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              inc, carry, inf_sel, big, tiny;
  logic [FRAC_W-1:0] frac_r;
  logic [XE_W-1:0]   exp_r;

  always_comb begin
    unique case (rmode_i)
      RM_RNE:  inc = rnd_i & (stk_i | frac_i[0]);
      RM_RTZ:  inc = 1'b0;
      RM_RUP:  inc = ~sign_i & (rnd_i | stk_i);
      default: inc = sign_i & (rnd_i | stk_i);
    endcase
  end

  // carry out of an all-ones fraction leaves a zero fraction and bumps the exponent
  assign {carry, frac_r} = {1'b0, frac_i} + (FRAC_W + 1)'(inc);
  assign exp_r   = exp_i + XE_W'(carry);
  assign big     = ~exp_r[XE_W-1] & (exp_r >= XE_W'(EMAX));
  assign tiny    = exp_r[XE_W-1] | (exp_r == '0);
  assign inf_sel = (rmode_i == RM_RNE) | ((rmode_i == RM_RUP) & ~sign_i) |
                   ((rmode_i == RM_RDN) & sign_i);

  always_comb begin
    ovf_o = 1'b0;
    unf_o = 1'b0;
    unique case (kind_i)
      K_NAN:  res_o = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      K_INF:  res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_ZERO: res_o = {sign_i, {(W-1){1'b0}}};
      default: begin
        if (big) begin
          ovf_o = 1'b1;
          res_o = inf_sel ? {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                          : {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else if (tiny) begin
          unf_o = 1'b1;
          res_o = {sign_i, {(W-1){1'b0}}};
        end else begin
          res_o = {sign_i, exp_r[EXP_W-1:0], frac_r};
        end
      end
    endcase
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int XE_W  = EXP_W + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   rmode_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic [W-1:0]     ops   [2];
  logic             sgn   [2];
  logic [EXP_W-1:0] ex    [2];
  logic [SIG_W-1:0] sig   [2];
  kind_e            kind  [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .op_i  (ops[g]),
      .sign_o(sgn[g]),
      .exp_o (ex[g]),
      .sig_o (sig[g]),
      .kind_o(kind[g])
    );
  end

  logic [XE_W-1:0]   m_exp;
  logic [FRAC_W-1:0] m_frac;
  logic              m_rnd, m_stk;

  fpm_sig_mul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul (
    .exp_a_i(ex[0]),
    .exp_b_i(ex[1]),
    .sig_a_i(sig[0]),
    .sig_b_i(sig[1]),
    .exp_o  (m_exp),
    .frac_o (m_frac),
    .rnd_o  (m_rnd),
    .stk_o  (m_stk)
  );

  kind_e pk_d;
  always_comb begin
    if (kind[0] == K_NAN || kind[1] == K_NAN)                 pk_d = K_NAN;
    else if ((kind[0] == K_ZERO && kind[1] == K_INF) ||
             (kind[0] == K_INF  && kind[1] == K_ZERO))        pk_d = K_NAN;
    else if (kind[0] == K_INF || kind[1] == K_INF)            pk_d = K_INF;
    else if (kind[0] == K_ZERO || kind[1] == K_ZERO)          pk_d = K_ZERO;
    else                                                      pk_d = K_FIN;
  end

  // stage 1
  logic              s1_valid, s1_sign, s1_rnd, s1_stk;
  kind_e             s1_kind;
  logic [XE_W-1:0]   s1_exp;
  logic [FRAC_W-1:0] s1_frac;
  rmode_e            s1_rmode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_rnd   <= 1'b0;
      s1_stk   <= 1'b0;
      s1_kind  <= K_FIN;
      s1_exp   <= '0;
      s1_frac  <= '0;
      s1_rmode <= RM_RNE;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sign  <= sgn[0] ^ sgn[1];
        s1_rnd   <= m_rnd;
        s1_stk   <= m_stk;
        s1_kind  <= pk_d;
        s1_exp   <= m_exp;
        s1_frac  <= m_frac;
        s1_rmode <= rmode_e'(rmode_i);
      end
    end
  end

  logic [W-1:0] rp_res;
  logic         rp_ovf, rp_unf;

  fpm_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .kind_i (s1_kind),
    .sign_i (s1_sign),
    .exp_i  (s1_exp),
    .frac_i (s1_frac),
    .rnd_i  (s1_rnd),
    .stk_i  (s1_stk),
    .rmode_i(s1_rmode),
    .res_o  (rp_res),
    .ovf_o  (rp_ovf),
    .unf_o  (rp_unf)
  );

  // stage 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        result_o <= rp_res;
        ovf_o    <= rp_ovf;
        unf_o    <= rp_unf;
      end
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   rmode_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         ovf_o,
  input logic         unf_o
);
  localparam logic [W-1:0] CNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic a_emax, b_emax, a_ez, b_ez, any_nan, zero_inf, r_inf, r_maxf;
  assign a_emax   = &a_i[W-2:FRAC_W];
  assign b_emax   = &b_i[W-2:FRAC_W];
  assign a_ez     = ~|a_i[W-2:FRAC_W];
  assign b_ez     = ~|b_i[W-2:FRAC_W];
  assign any_nan  = (a_emax & |a_i[FRAC_W-1:0]) | (b_emax & |b_i[FRAC_W-1:0]);
  assign zero_inf = (a_ez & b_emax) | (b_ez & a_emax);
  assign r_inf    = (&result_o[W-2:FRAC_W]) & ~|result_o[FRAC_W-1:0];
  assign r_maxf   = (result_o[W-2:FRAC_W] == {{(EXP_W-1){1'b1}}, 1'b0}) &
                    (&result_o[FRAC_W-1:0]);

  a_r13_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc[1] |-> (valid_o == $past(valid_i, 2)));

  a_r9_nan_canonical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc[1] && $past(valid_i, 2) && $past(any_nan, 2)) |->
      (result_o == CNAN && !ovf_o && !unf_o));

  a_r1_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc[1] && $past(valid_i, 2) && !$past(any_nan, 2) && !$past(zero_inf, 2)) |->
      (result_o[W-1] == $past(a_i[W-1] ^ b_i[W-1], 2)));

  a_r7_ovf_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (r_inf || r_maxf) && !unf_o);

  a_r7_ovf_rne_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc[1] && valid_o && ovf_o && $past(rmode_i, 2) == 2'd0) |-> r_inf);

  a_r8_unf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && unf_o) |-> (result_o[W-2:0] == '0));
endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .rmode_i (rmode_i),
  .valid_o (valid_o),
  .result_o(result_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o)
);

// File: tb/fpm_mul_test.sv
module fpm_mul_test;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int W  = 1 + EW + FW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   rmode_i = '0;
  logic         valid_o, ovf_o, unf_o;
  logic [W-1:0] result_o;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpm_mul #(.EXP_W(EW), .FRAC_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .rmode_i(rmode_i), .valid_o(valid_o), .result_o(result_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // expected pipeline, index 1 is due at the current falling edge
  bit           ev [2];
  logic [W-1:0] er [2];
  logic         eo [2], eu [2];
  string        et [2];
  logic [W-1:0] ea_h [2], eb_h [2];
  logic [1:0]   em_h [2];

  function automatic void model(input logic [7:0] a, input logic [7:0] b, input logic [1:0] rm,
                                output logic [7:0] r, output logic ov, output logic un,
                                output string tag);
    int xa, xb, fa, fb, p, e, sh, keep, rem, half;
    logic s;
    bit an, bn, ai, bi, az, bz, inc, carry, up;
    s  = a[7] ^ b[7];
    xa = int'(a[6:3]); xb = int'(b[6:3]);
    fa = int'(a[2:0]); fb = int'(b[2:0]);
    an = (xa == 15) && (fa != 0); bn = (xb == 15) && (fb != 0);
    ai = (xa == 15) && (fa == 0); bi = (xb == 15) && (fb == 0);
    az = (xa == 0);               bz = (xb == 0);
    ov = 1'b0; un = 1'b0;
    if (an || bn) begin
      r = 8'h7C; tag = "R9";
    end else if ((az && bi) || (ai && bz)) begin
      r = 8'h7C; tag = "R10";
    end else if (ai || bi) begin
      r = {s, 7'h78}; tag = "R11";
    end else if (az || bz) begin
      r = {s, 7'h00}; tag = "R12";
    end else begin
      p = (8 + fa) * (8 + fb);
      e = xa + xb - 7;
      if (p >= 128) begin sh = 4; e = e + 1; end
      else sh = 3;
      keep = p >> sh;
      rem  = p % (1 << sh);
      half = 1 << (sh - 1);
      case (rm)
        2'd0:    inc = (rem > half) || (rem == half && (keep % 2) == 1);
        2'd1:    inc = 1'b0;
        2'd2:    inc = (rem != 0) && !s;
        default: inc = (rem != 0) && s;
      endcase
      keep  = keep + int'(inc);
      carry = (keep == 16);
      if (carry) begin keep = 8; e = e + 1; end
      if (e >= 15) begin
        ov = 1'b1;
        up = (rm == 2'd0) || (rm == 2'd2 && !s) || (rm == 2'd3 && s);
        r  = up ? {s, 7'h78} : {s, 7'h77};
        tag = "R7";
      end else if (e < 1) begin
        un = 1'b1; r = {s, 7'h00}; tag = "R8";
      end else begin
        r = {s, 4'(e), 3'(keep % 8)};
        if (carry)          tag = "R6";
        else if (rem == 0)  tag = "R2";
        else if (rm == 2'd0) tag = "R3";
        else if (rm == 2'd1) tag = "R4";
        else                 tag = "R5";
      end
    end
  endfunction

  task automatic check_out();
    total++;
    if (valid_o !== ev[1]) begin
      fails++;
      $display("FAIL R13: valid_o=%b expected %b", valid_o, ev[1]);
    end
    if (ev[1] && valid_o === 1'b1) begin
      total++;
      if ({result_o, ovf_o, unf_o} !== {er[1], eo[1], eu[1]}) begin
        fails++;
        $display("FAIL %s: a=%h b=%h rm=%0d got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                 et[1], ea_h[1], eb_h[1], em_h[1], result_o, ovf_o, unf_o, er[1], eo[1], eu[1]);
      end
      if (er[1] != 8'h7C) begin
        total++; // R1 sign
        if (result_o[7] !== er[1][7]) begin
          fails++;
          $display("FAIL R1: a=%h b=%h sign=%b expected %b", ea_h[1], eb_h[1], result_o[7], er[1][7]);
        end
      end
    end
  endtask

  task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b, input logic [1:0] rm);
    logic [7:0] r;
    logic ov, un;
    string tag;
    @(negedge clk);
    check_out();
    ev[1] = ev[0]; er[1] = er[0]; eo[1] = eo[0]; eu[1] = eu[0]; et[1] = et[0];
    ea_h[1] = ea_h[0]; eb_h[1] = eb_h[0]; em_h[1] = em_h[0];
    model(a, b, rm, r, ov, un, tag);
    ev[0] = v; er[0] = r; eo[0] = ov; eu[0] = un; et[0] = tag;
    ea_h[0] = a; eb_h[0] = b; em_h[0] = rm;
    valid_i = v; a_i = a; b_i = b; rmode_i = rm;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      ev[i] = 1'b0; er[i] = '0; eo[i] = 1'b0; eu[i] = 1'b0; et[i] = "R13";
      ea_h[i] = '0; eb_h[i] = '0; em_h[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R13 reset state
    total++;
    if ({valid_o, result_o, ovf_o, unf_o} !== '0) begin
      fails++;
      $display("FAIL R13: reset outputs %b %h %b %b expected all zero", valid_o, result_o, ovf_o, unf_o);
    end
    rst_n = 1'b1;
    // nearest-even: every pair, one idle cycle per row
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) step(1'b1, 8'(a), 8'(b), 2'd0);
      step(1'b0, 8'h00, 8'h00, 2'd0);
    end
    // directed and truncating modes on a strided subset
    for (int m = 1; m < 4; m++) begin
      for (int a = 0; a < 256; a += 4) begin
        for (int b = 0; b < 256; b++) step(1'b1, 8'(a + (m % 4)), 8'(b), 2'(m));
        step(1'b0, 8'h00, 8'h00, 2'(m));
      end
    end
    step(1'b0, 8'h00, 8'h00, 2'd0);
    step(1'b0, 8'h00, 8'h00, 2'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R13: watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule